// File: doc/BRIEF.md
# Append-Slot Word Store Controller

This block manages an emulated non-volatile store of 32-bit words whose cells cannot be rewritten in place. The storage is modelled in registers. Words are grouped into blocks of sixteen, and every word owns a fixed number of physical slots. A write appends the new value to the next free slot of its word, so repeated writes to one word need no erase until that word's slots run out. When a write finds its word full, the controller protects the whole block during the erase. It first copies the newest value of each of the block's words into a single spare copy buffer. It then erases the block, restores each copied word into slot 0, and finally programs the pending value.

The copy buffer is left holding data after it is used. The next protective erase therefore has to clean it first, which costs one more erase period. Software can avoid that penalty by issuing the buffer-erase command at a quiet moment.

The write port is a single-cycle request qualified by `busy`. A request made while the controller is busy is refused with a one-cycle `err` pulse. The read port runs independently and is never stalled. A word always reads as its last committed value, even while that value sits only in the copy buffer. Program and erase times are parameters counted in clock cycles.

Top module: `ee_slot_store`

## Requirements
- R1: After reset `busy`, `done` and `err` are low and every word reads 0xFFFFFFFF.
- R2: A write to a word with a free slot keeps `busy` high for exactly PROG_CYC cycles. `done` is then high for one cycle with `busy` low, and the word reads the new value.
- R3: Successive writes to one word, up to SLOTS writes in total, each take only PROG_CYC cycles, and each read returns the newest value.
- R4: A write to a word whose SLOTS slots are full, with a clean copy buffer, keeps `busy` high for 2*WORDS_PER_BLK*PROG_CYC + ERASE_CYC + PROG_CYC cycles. Afterwards the word holds the new value, the other words of its block keep their values, and other blocks are untouched.
- R5: After a protective erase the rewritten word occupies two slots. It accepts SLOTS-2 further writes at PROG_CYC each, and the write after those triggers another erase.
- R6: A protective erase that finds the copy buffer holding data takes ERASE_CYC cycles longer than the R4 duration.
- R7: A `cbuf_erase` pulse while idle keeps `busy` high for ERASE_CYC cycles without a `done` pulse. The next protective erase then takes the R4 duration.
- R8: While a write or erase sequence runs, `rd_data` of the target word and of every other word in the block stays at the previously committed value.
- R9: A `wr_req` or `cbuf_erase` that arrives while `busy` is high is refused. `err` goes high for one cycle, and the refused write leaves its word unchanged.
- R10: A word that was erased and never written stays at 0xFFFFFFFF through a protective erase of its block. Its next write then takes only PROG_CYC cycles.
- R11: `rd_data` shows the word addressed by `rd_addr` one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write request, one cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Value to store |
| cbuf_erase | input | 1 | Command to erase the copy buffer |
| rd_addr | input | ADDR_W | Word address for reading |
| rd_data | output | DATA_W | Committed value of the addressed word |
| busy | output | 1 | Controller is running a sequence |
| done | output | 1 | One-cycle pulse when a write completes |
| err | output | 1 | One-cycle pulse when a request is refused |

## Verification
The bench builds the block with NUM_BLKS=4, PROG_CYC=2 and ERASE_CYC=5. The full-word erase therefore lasts 71 cycles with a clean buffer and 76 cycles with a dirty one, and both durations are counted exactly. With four blocks the bench can show that an erase in block 0 leaves block 1 and block 2 intact. It can also fill a word in a second block after the buffer command. Short program and erase times make it cheap to watch the read port across every busy cycle of a protective erase and to land refused requests inside a running sequence.

// File: rtl/ee_store_pkg.sv
package ee_store_pkg;

   typedef enum logic [2:0] {
      ST_IDLE        = 3'd0,
      ST_PROGRAM     = 3'd1,
      ST_COPY_OUT    = 3'd2,
      ST_ERASE_BLOCK = 3'd3,
      ST_COPY_BACK   = 3'd4,
      ST_ERASE_CBUF  = 3'd5
   } ee_state_t;

endpackage

// File: rtl/ee_step_timer.sv
module ee_step_timer #(
   parameter int CYC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CYC_W-1:0] len,
   output logic             expire
);

   logic [CYC_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len - CYC_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CYC_W'(1);
      end
   end

   assign expire = (cnt_q == '0);

endmodule

// File: rtl/ee_word_array.sv
module ee_word_array #(
   parameter int DATA_W        = 32,
   parameter int WORDS_PER_BLK = 16,
   parameter int NUM_BLKS      = 32,
   parameter int SLOTS         = 7,
   localparam int WORDS        = WORDS_PER_BLK * NUM_BLKS,
   localparam int ADDR_W       = $clog2(WORDS),
   localparam int IDX_W        = $clog2(WORDS_PER_BLK),
   localparam int BLK_W        = ADDR_W - IDX_W,
   localparam int SLOT_W       = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              app_en,
   input  logic [ADDR_W-1:0] app_addr,
   input  logic [DATA_W-1:0] app_data,
   input  logic              res_en,
   input  logic [ADDR_W-1:0] res_addr,
   input  logic [DATA_W-1:0] res_data,
   input  logic              res_fill,
   input  logic              ers_en,
   input  logic [BLK_W-1:0]  ers_blk,
   input  logic [ADDR_W-1:0] ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_data,
   output logic [SLOT_W-1:0] q_used
);

   localparam logic [DATA_W-1:0] BLANK = '1;

   logic [DATA_W-1:0] val_q  [WORDS];
   logic [SLOT_W-1:0] used_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) begin
            val_q[i]  <= BLANK;
            used_q[i] <= '0;
         end
      end else begin
         if (app_en) begin
            val_q[app_addr]  <= app_data;
            used_q[app_addr] <= used_q[app_addr] + SLOT_W'(1);
         end
         if (res_en) begin
            val_q[res_addr]  <= res_fill ? res_data : BLANK;
            used_q[res_addr] <= res_fill ? SLOT_W'(1) : '0;
         end
         if (ers_en) begin
            for (int i = 0; i < WORDS_PER_BLK; i++) begin
               val_q[{ers_blk, IDX_W'(i)}]  <= BLANK;
               used_q[{ers_blk, IDX_W'(i)}] <= '0;
            end
         end
      end
   end

   assign ra_data = val_q[ra_addr];
   assign q_data  = val_q[q_addr];
   assign q_used  = used_q[q_addr];

endmodule

// File: rtl/ee_copy_buf.sv
module ee_copy_buf #(
   parameter int DATA_W        = 32,
   parameter int WORDS_PER_BLK = 16,
   localparam int IDX_W        = $clog2(WORDS_PER_BLK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_fill,
   input  logic              clr,
   input  logic [IDX_W-1:0]  a_idx,
   output logic [DATA_W-1:0] a_data,
   output logic              a_fill,
   input  logic [IDX_W-1:0]  b_idx,
   output logic [DATA_W-1:0] b_data,
   output logic              b_fill,
   output logic              dirty
);

   logic [DATA_W-1:0]        ent_q [WORDS_PER_BLK];
   logic [WORDS_PER_BLK-1:0] fill_q;
   logic                     dirty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS_PER_BLK; i++) begin
            ent_q[i] <= '1;
         end
         fill_q  <= '0;
         dirty_q <= 1'b0;
      end else if (clr) begin
         for (int i = 0; i < WORDS_PER_BLK; i++) begin
            ent_q[i] <= '1;
         end
         fill_q  <= '0;
         dirty_q <= 1'b0;
      end else if (wr_en) begin
         ent_q[wr_idx]  <= wr_data;
         fill_q[wr_idx] <= wr_fill;
         dirty_q        <= 1'b1;
      end
   end

   assign a_data = ent_q[a_idx];
   assign a_fill = fill_q[a_idx];
   assign b_data = ent_q[b_idx];
   assign b_fill = fill_q[b_idx];
   assign dirty  = dirty_q;

endmodule

// File: rtl/ee_slot_store.sv
module ee_slot_store
   import ee_store_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int WORDS_PER_BLK = 16,
   parameter int NUM_BLKS      = 32,
   parameter int SLOTS         = 7,
   parameter int CYC_W         = 16,
   parameter int PROG_CYC      = 4,
   parameter int ERASE_CYC     = 40,
   parameter bit RD_REG        = 1'b1,
   localparam int WORDS        = WORDS_PER_BLK * NUM_BLKS,
   localparam int ADDR_W       = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cbuf_erase,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              err
);

   localparam int IDX_W  = $clog2(WORDS_PER_BLK);
   localparam int BLK_W  = ADDR_W - IDX_W;
   localparam int SLOT_W = $clog2(SLOTS + 1);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORDS_PER_BLK - 1);
   localparam logic [CYC_W-1:0]  P_LEN    = CYC_W'(PROG_CYC);
   localparam logic [CYC_W-1:0]  E_LEN    = CYC_W'(ERASE_CYC);
   localparam logic [SLOT_W-1:0] FULL_CNT = SLOT_W'(SLOTS);

   // elaboration-time parameter checks
   if (WORDS_PER_BLK < 2 || (1 << IDX_W) != WORDS_PER_BLK) begin : g_bad_blk
      $error("WORDS_PER_BLK must be a power of two of at least 2");
   end
   if (NUM_BLKS < 1 || (1 << BLK_W) != NUM_BLKS) begin : g_bad_nblk
      $error("NUM_BLKS must be a power of two");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || PROG_CYC >= (1 << CYC_W) || ERASE_CYC >= (1 << CYC_W)) begin : g_bad_cyc
      $error("cycle counts must be at least 1 and fit CYC_W");
   end

   ee_state_t         state_q, state_d;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_data_q;
   logic              pend_wr_q, pend_wr_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic              take, fin;
   logic              done_q, err_q;

   logic              t_load, t_exp;
   logic [CYC_W-1:0]  t_len;

   logic              app_en, res_en, ers_en;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_data, a_data;
   logic [SLOT_W-1:0] q_used;

   logic              cb_wr, cb_clr, cb_dirty;
   logic [DATA_W-1:0] cb_a_data, cb_b_data;
   logic              cb_a_fill, cb_b_fill;

   logic [BLK_W-1:0]  pend_blk;
   logic [ADDR_W-1:0] walk_addr;
   logic              rd_from_cbuf;
   logic [DATA_W-1:0] rd_word;

   assign pend_blk  = pend_addr_q[ADDR_W-1:IDX_W];
   assign walk_addr = {pend_blk, idx_q};
   assign q_addr    = (state_q == ST_IDLE) ? wr_addr : walk_addr;

   ee_step_timer #(.CYC_W(CYC_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (t_load),
      .len    (t_len),
      .expire (t_exp)
   );

   ee_word_array #(
      .DATA_W        (DATA_W),
      .WORDS_PER_BLK (WORDS_PER_BLK),
      .NUM_BLKS      (NUM_BLKS),
      .SLOTS         (SLOTS)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .app_en   (app_en),
      .app_addr (pend_addr_q),
      .app_data (pend_data_q),
      .res_en   (res_en),
      .res_addr (walk_addr),
      .res_data (cb_b_data),
      .res_fill (cb_b_fill),
      .ers_en   (ers_en),
      .ers_blk  (pend_blk),
      .ra_addr  (rd_addr),
      .ra_data  (a_data),
      .q_addr   (q_addr),
      .q_data   (q_data),
      .q_used   (q_used)
   );

   ee_copy_buf #(
      .DATA_W        (DATA_W),
      .WORDS_PER_BLK (WORDS_PER_BLK)
   ) u_cbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cb_wr),
      .wr_idx  (idx_q),
      .wr_data (q_data),
      .wr_fill (q_used != '0),
      .clr     (cb_clr),
      .a_idx   (rd_addr[IDX_W-1:0]),
      .a_data  (cb_a_data),
      .a_fill  (cb_a_fill),
      .b_idx   (idx_q),
      .b_data  (cb_b_data),
      .b_fill  (cb_b_fill),
      .dirty   (cb_dirty)
   );

   // sequencer
   always_comb begin
      state_d   = state_q;
      pend_wr_d = pend_wr_q;
      idx_d     = idx_q;
      t_load    = 1'b0;
      t_len     = P_LEN;
      app_en    = 1'b0;
      res_en    = 1'b0;
      ers_en    = 1'b0;
      cb_wr     = 1'b0;
      cb_clr    = 1'b0;
      take      = 1'b0;
      fin       = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (wr_req) begin
               take   = 1'b1;
               t_load = 1'b1;
               idx_d  = '0;
               if (q_used == FULL_CNT) begin
                  if (cb_dirty) begin
                     state_d   = ST_ERASE_CBUF;
                     t_len     = E_LEN;
                     pend_wr_d = 1'b1;
                  end else begin
                     state_d = ST_COPY_OUT;
                  end
               end else begin
                  state_d = ST_PROGRAM;
               end
            end else if (cbuf_erase) begin
               state_d   = ST_ERASE_CBUF;
               t_load    = 1'b1;
               t_len     = E_LEN;
               pend_wr_d = 1'b0;
            end
         end
         ST_PROGRAM: begin
            if (t_exp) begin
               app_en  = 1'b1;
               fin     = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_ERASE_CBUF: begin
            if (t_exp) begin
               cb_clr = 1'b1;
               if (pend_wr_q) begin
                  state_d = ST_COPY_OUT;
                  t_load  = 1'b1;
                  idx_d   = '0;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_COPY_OUT: begin
            if (t_exp) begin
               cb_wr  = 1'b1;
               t_load = 1'b1;
               if (idx_q == LAST_IDX) begin
                  state_d = ST_ERASE_BLOCK;
                  t_len   = E_LEN;
               end else begin
                  idx_d = idx_q + IDX_W'(1);
               end
            end
         end
         ST_ERASE_BLOCK: begin
            if (t_exp) begin
               ers_en  = 1'b1;
               state_d = ST_COPY_BACK;
               t_load  = 1'b1;
               idx_d   = '0;
            end
         end
         ST_COPY_BACK: begin
            if (t_exp) begin
               res_en = 1'b1;
               t_load = 1'b1;
               if (idx_q == LAST_IDX) begin
                  state_d = ST_PROGRAM;
               end else begin
                  idx_d = idx_q + IDX_W'(1);
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_addr_q <= '0;
         pend_data_q <= '0;
         pend_wr_q   <= 1'b0;
         idx_q       <= '0;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         state_q   <= state_d;
         pend_wr_q <= pend_wr_d;
         idx_q     <= idx_d;
         done_q    <= fin;
         err_q     <= (wr_req || cbuf_erase) && (state_q != ST_IDLE);
         if (take) begin
            pend_addr_q <= wr_addr;
            pend_data_q <= wr_data;
         end
      end
   end

   // words not yet restored after the erase live only in the copy buffer
   assign rd_from_cbuf = (state_q == ST_COPY_BACK) &&
                         (rd_addr[ADDR_W-1:IDX_W] == pend_blk) &&
                         (rd_addr[IDX_W-1:0] >= idx_q);
   assign rd_word = rd_from_cbuf ? (cb_a_fill ? cb_a_data : '1) : a_data;

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '1;
         else        rd_q <= rd_word;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_word;
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign err  = err_q;

endmodule

// File: rtl/ee_slot_store_chk.sv
module ee_slot_store_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_req,
   input logic cbuf_erase,
   input logic busy,
   input logic done,
   input logic err
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                           // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                           // R2
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));                                     // R2
   AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy) |=> busy);                               // R2
   AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cbuf_erase && !wr_req && !busy) |=> busy);                // R7
   AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_req || cbuf_erase) && busy) |=> err);                 // R9
   AST_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(busy));                                      // R9

endmodule

bind ee_slot_store ee_slot_store_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_req     (wr_req),
   .cbuf_erase (cbuf_erase),
   .busy       (busy),
   .done       (done),
   .err        (err)
);

// File: tb/ee_slot_store_test.sv
module ee_slot_store_test;

   localparam int DW   = 32;
   localparam int WPB  = 16;
   localparam int NB   = 4;
   localparam int SL   = 7;
   localparam int PC   = 2;
   localparam int EC   = 5;
   localparam int AW   = $clog2(WPB * NB);
   localparam int T_PLAIN = PC;
   localparam int T_CLEAN = 2 * WPB * PC + EC + PC;
   localparam int T_DIRTY = T_CLEAN + EC;
   localparam logic [DW-1:0] BLANK = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          cbuf_erase = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          busy, done, err;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   ee_slot_store #(
      .DATA_W(DW), .WORDS_PER_BLK(WPB), .NUM_BLKS(NB), .SLOTS(SL),
      .PROG_CYC(PC), .ERASE_CYC(EC)
   ) uut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .cbuf_erase(cbuf_erase), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [DW-1:0] v);
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      v = rd_data;
   endtask

   // issue a write, count busy cycles until done, optionally watch rd_data
   task automatic do_write(input int a, input logic [DW-1:0] d, input int exp_cyc,
                           input bit watch, input int w_addr, input logic [DW-1:0] w_val,
                           input string tag);
      int n = 0;
      bit seen = 0;
      bit w_ok = 1;
      logic [DW-1:0] w_bad = '0;
      @(negedge clk);
      rd_addr = AW'(w_addr);
      wr_req  = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      @(negedge clk);
      wr_req = 1'b0;
      for (int k = 0; k < 2000; k++) begin
         if (done) begin
            seen = 1;
            break;
         end
         if (busy) begin
            n++;
            if (watch && rd_data !== w_val) begin
               w_ok  = 0;
               w_bad = rd_data;
            end
         end
         @(negedge clk);
      end
      chk(seen && !busy, {tag, " done with busy low"}, DW'(seen), 1);
      chk(n == exp_cyc, {tag, " busy cycles"}, DW'(n), DW'(exp_cyc));
      if (watch) chk(w_ok, {tag, " read held during sequence"}, w_bad, w_val);
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      chk(!busy && !done && !err, "R1 idle outputs", {busy, done, err}, 0);
      rd(0, v);              chk(v === BLANK, "R1 word 0 blank", v, BLANK);
      rd(WPB * NB - 1, v);   chk(v === BLANK, "R1 last word blank", v, BLANK);
      rd(21, v);             chk(v === BLANK, "R1 mid word blank", v, BLANK);
   endtask

   task automatic t_basic;
      logic [DW-1:0] v;
      do_write(5, 32'h1111_0000, T_PLAIN, 0, 0, 0, "R2 first write");
      rd(5, v); chk(v === 32'h1111_0000, "R2 readback", v, 32'h1111_0000);
      // R11: one-cycle read latency when address changes
      @(negedge clk); rd_addr = AW'(5);
      @(negedge clk); rd_addr = AW'(6);
      chk(rd_data === 32'h1111_0000, "R11 word 5 after one cycle", rd_data, 32'h1111_0000);
      @(negedge clk);
      chk(rd_data === BLANK, "R11 word 6 after one cycle", rd_data, BLANK);
   endtask

   task automatic t_append;
      logic [DW-1:0] v;
      for (int k = 1; k < SL; k++) begin
         do_write(5, 32'h1111_0000 + DW'(k), T_PLAIN, 0, 0, 0, "R3 append");
         rd(5, v); chk(v === 32'h1111_0000 + DW'(k), "R3 newest slot", v, 32'h1111_0000 + DW'(k));
      end
      do_write(3, 32'h3333_3333, T_PLAIN, 0, 0, 0, "R3 neighbour write");
      do_write(16, 32'hC0C0_C0C0, T_PLAIN, 0, 0, 0, "R3 other block write");
   endtask

   task automatic t_erase_clean;
      logic [DW-1:0] v;
      do_write(5, 32'hAAAA_0001, T_CLEAN, 1, 5, 32'h1111_0006, "R4 R8 full word clean cbuf");
      rd(5, v);  chk(v === 32'hAAAA_0001, "R4 new value", v, 32'hAAAA_0001);
      rd(3, v);  chk(v === 32'h3333_3333, "R4 neighbour kept", v, 32'h3333_3333);
      rd(16, v); chk(v === 32'hC0C0_C0C0, "R4 other block kept", v, 32'hC0C0_C0C0);
      rd(6, v);  chk(v === BLANK, "R10 blank word stays blank", v, BLANK);
   endtask

   task automatic t_refill_dirty;
      logic [DW-1:0] v;
      for (int k = 2; k < SL; k++) begin
         do_write(5, 32'hAAAA_0000 + DW'(k), T_PLAIN, 0, 0, 0, "R5 refill after erase");
      end
      rd(5, v); chk(v === 32'hAAAA_0006, "R5 newest after refill", v, 32'hAAAA_0006);
      do_write(5, 32'hBBBB_0000, T_DIRTY, 1, 3, 32'h3333_3333, "R6 R8 dirty cbuf erase");
      rd(5, v); chk(v === 32'hBBBB_0000, "R6 new value", v, 32'hBBBB_0000);
      do_write(6, 32'h6666_6666, T_PLAIN, 0, 0, 0, "R10 blank word plain write");
      rd(6, v); chk(v === 32'h6666_6666, "R10 readback", v, 32'h6666_6666);
   endtask

   task automatic t_refuse;
      logic [DW-1:0] v;
      int n = 1;
      bit seen_done = 0;
      @(negedge clk);
      cbuf_erase = 1'b1;
      @(negedge clk);
      cbuf_erase = 1'b0;
      chk(busy, "R9 busy for erase cmd", DW'(busy), 1);
      wr_req = 1'b1; wr_addr = AW'(50); wr_data = 32'h5050_5050;
      @(negedge clk); n++;
      wr_req = 1'b0;
      chk(err, "R9 err after refused write", DW'(err), 1);
      cbuf_erase = 1'b1;
      @(negedge clk); n++;
      cbuf_erase = 1'b0;
      chk(err, "R9 err after refused cmd", DW'(err), 1);
      @(negedge clk); n++;
      chk(!err, "R9 err single pulse", DW'(err), 0);
      for (int k = 0; k < 100 && busy; k++) begin
         if (done) seen_done = 1;
         @(negedge clk);
         if (busy) n++;
      end
      chk(n == EC, "R7 cmd busy cycles", DW'(n), DW'(EC));
      chk(!seen_done && !done, "R7 no done for cmd", DW'(done), 0);
      rd(50, v); chk(v === BLANK, "R9 refused write not stored", v, BLANK);
   endtask

   task automatic t_after_cmd;
      logic [DW-1:0] v;
      for (int k = 0; k < SL; k++) begin
         do_write(40, 32'h4040_0000 + DW'(k), T_PLAIN, 0, 0, 0, "R7 fill block 2 word");
      end
      do_write(40, 32'h4040_FFFF, T_CLEAN, 0, 0, 0, "R7 erase after cmd is clean");
      rd(40, v); chk(v === 32'h4040_FFFF, "R7 readback", v, 32'h4040_FFFF);
      rd(5, v);  chk(v === 32'hBBBB_0000, "R4 block 0 untouched", v, 32'hBBBB_0000);
   endtask

   bit finished = 0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_append();
      t_erase_clean();
      t_refill_dirty();
      t_refuse();
      t_after_cmd();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog run did not complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule